// File: doc/BRIEF.md
# Memory Bus Profiling Counter Unit

This unit sits beside the internal command interface of a DRAM controller and measures how that interface is used. It watches a valid/ready command bus, one command per accepted cycle. Each command carries a direction flag and a byte count. From this bus it keeps six free-running counters: total cycles, busy cycles, read commands, write commands, read bytes and write bytes.

Software programs a single control word to clear, start and freeze the counters, and reads them through a 32-bit register port. The counters wrap silently and there is no interrupt. Software polls faster than the shortest wrap period and takes differences modulo the counter range. A sticky flag records that the cycle counter has wrapped at least once since the last clear.

A build option, `HAS_PROF_SEL`, adds a profile-select bit to the control word. The bit only selects a profiling variant in the controller and changes nothing inside this unit.

Top module: `mem_prof_unit`

## Requirements
- R1: The control word is at byte offset 0x410. Its fields are enable at bit 0, clear at bit 1, freeze at bit 2, cycle-wrap flag at bit 3 and profile select at bit 4. The clear bit always reads 0, the wrap flag cannot be written, and every field reads 0 after reset.
- R2: A control write with bit 1 set clears all six counters and the wrap flag at that clock edge. The stored enable becomes 0 even if bit 0 was set in the same write.
- R3: The unit is running while enable is 1 and freeze is 0. While it runs, the total-cycles counter at offset 0x418 increments by one on every clock.
- R4: While the unit runs, the busy-cycles counter at offset 0x41C increments on every clock in which `bus_valid_i` is high, whether or not the command is accepted.
- R5: While the unit runs, an accepted command (valid and ready both high) increments the read-access counter at 0x420 when `bus_write_i` is 0, or the write-access counter at 0x424 when it is 1.
- R6: While the unit runs, an accepted command adds `bus_bytes_i` to the read-byte counter at 0x428 for a read, or to the write-byte counter at 0x42C for a write.
- R7: While the unit is not running, including when frozen or after a control write of zero, all counters hold their values and can still be read.
- R8: Each counter is `CNT_W` bits wide and wraps modulo 2^CNT_W with no saturation. Its value reads back zero-extended to 32 bits.
- R9: The cycle-wrap flag is set when the total-cycles counter passes from all ones to zero. After that it stays set until a clearing control write.
- R10: Writes to counter offsets or to unmapped offsets change nothing. Reads of any offset other than the seven mapped ones, unaligned offsets included, return zero.
- R11: When `HAS_PROF_SEL` is 0, profile select always reads 0. When it is 1, the bit holds the last value written. In both builds it has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 12 | Register byte offset, used for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational from the registers |
| bus_valid_i | input | 1 | Monitored bus: command valid |
| bus_ready_i | input | 1 | Monitored bus: command accepted when high with valid |
| bus_write_i | input | 1 | Monitored bus: 1 for write, 0 for read |
| bus_bytes_i | input | BYTES_W | Monitored bus: byte count of the command |

## Verification
A control write or a bus event at clock edge N appears in the register read data one cycle later. Because the read path has no register, `reg_rdata_o` settles within the same cycle and can be sampled at the falling edge right after edge N. Two values are read that same cycle: the counters updated at edge N and the control fields written at edge N. The bench advances its reference model at every rising edge from the inputs it drove half a cycle earlier. At each falling edge it compares the read data for the current offset with the model before it changes any input. A clearing write together with an enable therefore shows zero counters and a cleared enable one cycle later. A frozen counter must read the same value on every later cycle.

// File: rtl/mprof_pkg.sv
package mprof_pkg;
  localparam int NUM_EVT = 6;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 12'h410;
  localparam logic [ADDR_W-1:0] CNT_BASE = 12'h418;

  localparam int B_EN = 0;
  localparam int B_CLR = 1;
  localparam int B_FRZ = 2;
  localparam int B_WRAP = 3;
  localparam int B_SEL = 4;

  typedef enum int {
    EV_TOTAL = 0,
    EV_BUSY = 1,
    EV_RD_CMD = 2,
    EV_WR_CMD = 3,
    EV_RD_BYTE = 4,
    EV_WR_BYTE = 5
  } evt_e;

  typedef struct packed {
    logic sel;
    logic wrap;
    logic frz;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/mprof_ctrl.sv
module mprof_ctrl
  import mprof_pkg::*;
#(
  parameter int HAS_PROF_SEL = 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  logic  en_bit_i,
  input  logic  clr_bit_i,
  input  logic  frz_bit_i,
  input  logic  sel_bit_i,
  input  logic  tot_wrap_i,
  output logic  clr_o,
  output logic  run_o,
  output ctrl_t ctrl_o
);
  localparam logic SEL_OK = (HAS_PROF_SEL != 0);

  ctrl_t ctrl_q;

  assign clr_o = wr_i & clr_bit_i;
  // clearing write blocks counting in its own cycle
  assign run_o = ctrl_q.en & ~ctrl_q.frz & ~clr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (clr_o) ctrl_q.wrap <= 1'b0;
      else if (tot_wrap_i) ctrl_q.wrap <= 1'b1;
      if (wr_i) begin
        ctrl_q.en  <= en_bit_i & ~clr_bit_i;
        ctrl_q.frz <= frz_bit_i;
        ctrl_q.sel <= sel_bit_i & SEL_OK;
      end
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/mprof_counter.sv
module mprof_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_en_i,
  input  logic [CNT_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt_q} + {1'b0, inc_i};
  assign wrap_o = inc_en_i & sum[CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_en_i) cnt_q <= sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mprof_rdmux.sv
module mprof_rdmux
  import mprof_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  ctrl_t                    ctrl_i,
  input  logic [NUM_EVT*CNT_W-1:0] cnt_i,
  output logic [31:0]              rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFS) begin
      rdata_o[B_EN]   = ctrl_i.en;
      rdata_o[B_FRZ]  = ctrl_i.frz;
      rdata_o[B_WRAP] = ctrl_i.wrap;
      rdata_o[B_SEL]  = ctrl_i.sel;
    end
    for (int i = 0; i < NUM_EVT; i++) begin
      if (addr_i == ADDR_W'(CNT_BASE + 4 * i)) rdata_o[CNT_W-1:0] = cnt_i[i*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/mem_prof_unit.sv
module mem_prof_unit
  import mprof_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BYTES_W = 8,
  parameter int HAS_PROF_SEL = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               bus_valid_i,
  input  logic               bus_ready_i,
  input  logic               bus_write_i,
  input  logic [BYTES_W-1:0] bus_bytes_i
);
  localparam int CNT_BITS = NUM_EVT * CNT_W;

  logic ctrl_wr, clr_w, run_w, acc_w;
  ctrl_t ctrl_w;
  logic [NUM_EVT-1:0] evt_on, evt_wrap;
  logic [CNT_W-1:0] evt_inc [NUM_EVT];
  logic [CNT_BITS-1:0] cnt_flat;
  logic unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[31:5], reg_wdata_i[B_WRAP], evt_wrap[NUM_EVT-1:1]};

  assign ctrl_wr = reg_wr_i & (reg_addr_i == CTRL_OFS);
  assign acc_w = bus_valid_i & bus_ready_i;

  mprof_ctrl #(.HAS_PROF_SEL(HAS_PROF_SEL)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .en_bit_i  (reg_wdata_i[B_EN]),
    .clr_bit_i (reg_wdata_i[B_CLR]),
    .frz_bit_i (reg_wdata_i[B_FRZ]),
    .sel_bit_i (reg_wdata_i[B_SEL]),
    .tot_wrap_i(evt_wrap[EV_TOTAL]),
    .clr_o     (clr_w),
    .run_o     (run_w),
    .ctrl_o    (ctrl_w)
  );

  always_comb begin
    evt_on[EV_TOTAL]   = run_w;
    evt_on[EV_BUSY]    = run_w & bus_valid_i;
    evt_on[EV_RD_CMD]  = run_w & acc_w & ~bus_write_i;
    evt_on[EV_WR_CMD]  = run_w & acc_w & bus_write_i;
    evt_on[EV_RD_BYTE] = run_w & acc_w & ~bus_write_i;
    evt_on[EV_WR_BYTE] = run_w & acc_w & bus_write_i;
    for (int i = 0; i < NUM_EVT; i++) evt_inc[i] = CNT_W'(1);
    evt_inc[EV_RD_BYTE] = CNT_W'(bus_bytes_i);
    evt_inc[EV_WR_BYTE] = CNT_W'(bus_bytes_i);
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
    mprof_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_w),
      .inc_en_i(evt_on[g]),
      .inc_i   (evt_inc[g]),
      .cnt_o   (cnt_flat[g*CNT_W +: CNT_W]),
      .wrap_o  (evt_wrap[g])
    );
  end

  mprof_rdmux #(.CNT_W(CNT_W)) u_rdmux (
    .addr_i (reg_addr_i),
    .ctrl_i (ctrl_w),
    .cnt_i  (cnt_flat),
    .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/mem_prof_unit_chk.sv
module mem_prof_unit_chk
  import mprof_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int HAS_PROF_SEL = 1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     reg_wr_i,
  input logic [ADDR_W-1:0]        reg_addr_i,
  input logic [31:0]              reg_wdata_i,
  input logic [31:0]              reg_rdata_o,
  input logic [NUM_EVT*CNT_W-1:0] cnt_flat,
  input logic                     wrap_flag,
  input logic                     run
);
  logic clr_wr, mapped;
  logic [CNT_W-1:0] tot, tot_inc;

  assign clr_wr = reg_wr_i && reg_addr_i == CTRL_OFS && reg_wdata_i[B_CLR];
  assign tot = cnt_flat[CNT_W-1:0];
  assign tot_inc = tot + CNT_W'(1);
  always_comb begin
    mapped = (reg_addr_i == CTRL_OFS);
    for (int i = 0; i < NUM_EVT; i++)
      if (reg_addr_i == ADDR_W'(CNT_BASE + 4 * i)) mapped = 1'b1;
  end

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (cnt_flat == '0 && !wrap_flag));

  assert_total_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> tot == $past(tot_inc));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !clr_wr) |=> $stable(cnt_flat));

  assert_wrap_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_flag && !clr_wr) |=> wrap_flag);

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> reg_rdata_o == '0);

  if (HAS_PROF_SEL == 0) begin : g_nosel
    assert_nosel_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_addr_i == CTRL_OFS |-> !reg_rdata_o[B_SEL]);
  end
endmodule

bind mem_prof_unit mem_prof_unit_chk #(.CNT_W(CNT_W), .HAS_PROF_SEL(HAS_PROF_SEL)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .cnt_flat   (cnt_flat),
  .wrap_flag  (ctrl_w.wrap),
  .run        (run_w)
);

// File: tb/mem_prof_unit_test.sv
module mem_prof_unit_test;
  localparam int CW = 10;
  localparam longint MASK = (64'd1 << CW) - 1;

  logic clk_i = 0, rst_ni = 0;
  logic wr = 0, hold = 0;
  logic [11:0] waddr = 0, haddr = 0, rot_addr, addr;
  logic [31:0] wdata = 0, rdata, rdata_ns;
  logic valid = 0, ready = 0, wflag = 0, traffic = 0;
  logic [7:0] bytes = 0;
  int rot = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  longint m_cnt[6];
  bit m_en, m_frz, m_sel, m_wrap;

  always #4 clk_i = ~clk_i;

  function automatic logic [11:0] rot_at(int k);
    case (k)
      0: return 12'h410;
      7: return 12'h500;
      8: return 12'h41A;
      default: return 12'(12'h418 + 4 * (k - 1));
    endcase
  endfunction
  assign rot_addr = rot_at(rot);
  assign addr = wr ? waddr : (hold ? haddr : rot_addr);

  mem_prof_unit #(.CNT_W(CW), .BYTES_W(8), .HAS_PROF_SEL(1)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .bus_valid_i(valid), .bus_ready_i(ready), .bus_write_i(wflag),
    .bus_bytes_i(bytes));

  mem_prof_unit #(.CNT_W(CW), .BYTES_W(8), .HAS_PROF_SEL(0)) uut_nosel (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_ns), .bus_valid_i(valid), .bus_ready_i(ready), .bus_write_i(wflag),
    .bus_bytes_i(bytes));

  // behavioural reference, advanced at each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      {m_en, m_frz, m_sel, m_wrap} = '0;
    end else begin
      bit cw, clr, go, acc;
      cw = wr && waddr == 12'h410;
      clr = cw && wdata[1];
      go = m_en && !m_frz && !clr;
      acc = valid && ready;
      if (clr) begin
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_wrap = 0;
      end else if (go) begin
        if (m_cnt[0] == MASK) m_wrap = 1;
        m_cnt[0] = (m_cnt[0] + 1) & MASK;
        if (valid) m_cnt[1] = (m_cnt[1] + 1) & MASK;
        if (acc && !wflag) begin
          m_cnt[2] = (m_cnt[2] + 1) & MASK;
          m_cnt[4] = (m_cnt[4] + bytes) & MASK;
        end
        if (acc && wflag) begin
          m_cnt[3] = (m_cnt[3] + 1) & MASK;
          m_cnt[5] = (m_cnt[5] + bytes) & MASK;
        end
      end
      if (cw) begin
        m_en = wdata[0] && !wdata[1];
        m_frz = wdata[2];
        m_sel = wdata[4];
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [11:0] a, bit opt);
    if (a == 12'h410) return {27'd0, opt ? m_sel : 1'b0, m_wrap, m_frz, 1'b0, m_en};
    for (int i = 0; i < 6; i++) if (a == 12'(12'h418 + 4 * i)) return 32'(m_cnt[i]);
    return 32'd0;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'h410: return "R1";
      12'h418: return "R3";
      12'h41C: return "R4";
      12'h420, 12'h424: return "R5";
      12'h428, 12'h42C: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, then next stimulus
  always @(negedge clk_i) begin
    if (!done) begin
      chk(tag_of(addr), rdata, exp_rd(addr, 1'b1));
      if (addr == 12'h410) chk("R11", rdata_ns, exp_rd(addr, 1'b0));
    end
    #1;
    rot = (rot + 1) % 9;
    if (traffic) begin
      valid = ($urandom % 4) != 0;
      ready = $urandom % 2;
      wflag = $urandom % 2;
      bytes = 8'($urandom);
    end else begin
      {valid, ready, wflag} = '0;
      bytes = 0;
    end
  end

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i); #1;
    wr = 1; waddr = a; wdata = d;
    @(negedge clk_i); #1;
    wr = 0;
  endtask

  task automatic reg_read(logic [11:0] a, output logic [31:0] v);
    @(negedge clk_i); #1;
    hold = 1; haddr = a;
    @(negedge clk_i);
    v = rdata;
    #1 hold = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1;
    reg_read(12'h410, v); chk("R1 reset ctrl", v, 32'h0);
    reg_read(12'h418, v); chk("R1 reset total", v, 32'h0);

    reg_write(12'h410, 32'h2);
    reg_write(12'h410, 32'h11);
    reg_read(12'h410, v); chk("R1 enable+sel", v, 32'h11);
    reg_read(12'h410, v); chk("R11 sel absent", rdata_ns, 32'h01);
    traffic = 1;
    idle(300);
    reg_write(12'h410, 32'h4);
    reg_read(12'h42C, v);
    idle(20);
    reg_read(12'h42C, v2); chk("R7 frozen hold", v2, v);
    chk("R7 frozen model", v2, exp_rd(12'h42C, 1'b1));

    reg_write(12'h41C, 32'hFFFF_FFFF);
    reg_read(12'h41C, v); chk("R10 counter write ignored", v, exp_rd(12'h41C, 1'b1));
    reg_write(12'h500, 32'h3FF);
    reg_read(12'h500, v); chk("R10 unmapped read", v, 32'h0);

    reg_write(12'h410, 32'h3);
    reg_read(12'h410, v); chk("R2 clear wins over enable", v, 32'h0);
    reg_read(12'h428, v); chk("R2 bytes cleared", v, 32'h0);

    traffic = 0;
    reg_write(12'h410, 32'h1);
    idle(int'(MASK) + 30);
    reg_read(12'h410, v); chk("R9 wrap flag set", v, 32'h9);
    reg_read(12'h418, v); chk("R8 total wrapped", v, exp_rd(12'h418, 1'b1));
    chk("R8 total small", 32'(v < 32'd64), 32'h1);
    reg_write(12'h410, 32'h1);
    reg_read(12'h410, v); chk("R9 flag sticky", v, 32'h9);
    reg_write(12'h410, 32'h2);
    reg_read(12'h410, v); chk("R2 flag cleared", v, 32'h0);

    reg_write(12'h410, 32'h1);
    traffic = 1;
    idle(150);
    reg_write(12'h410, 32'h0);
    reg_read(12'h424, v);
    idle(10);
    reg_read(12'h424, v2); chk("R7 disabled hold", v2, v);
    traffic = 0;
    idle(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule